// File: doc/BRIEF.md
# Bank Interrupt Router with Security Lock

This block takes the pending-interrupt bits of one GPIO bank (up to eight ports, each with up to eight pins) and steers them onto up to eight bank interrupt lines. Every combination of port and line owns an eight-bit route mask. A line fires when any pending pin of any port has its bit set in that line's mask for the port. One pin may feed any subset of the lines, so interrupt load can be spread across several handlers.

A security control register holds two sticky lock bits, one for reads and one for writes. Once either bit is set, the route masks are frozen against the normal register port until reset. The read lock also hides the mask contents. A read-only status register per port shows which pins of that port are pending. Ports may be narrower than eight pins. Bits that lie at or above a port's pin count are inert in both the masks and the status.

Top module: `bank_irq_router`

## Requirements
- R1: After a synchronous reset, both lock bits are clear, `bank_irq` is all zero, the line 0 mask of each port has one bit set for each existing pin of that port, and all other masks are zero.
- R2: The route mask for port p and line x sits at byte address 0x14 + p*0x20 + x*4. A read returns the mask in `reg_rdata[7:0]` with zeros above it, in the cycle after the read is sampled.
- R3: `bank_irq[x]` is registered. One cycle after a clock edge, it equals the OR over all ports and pins of (pending pin AND that port's line x mask bit), using the masks as they stood before that edge.
- R4: Port p has PORT_PINS[4p+3:4p] pins. Mask bits and pending inputs at or above that count have no effect. Such mask bits are stored and read back as zero.
- R5: The security control register is at address 0x0C. Bit 28 is the write lock and bit 27 is the read lock. Writing a 1 sets a bit. Writing a 0 never clears it, and only reset does. A read returns both bits in those positions and zeros elsewhere.
- R6: While either lock bit is set, writes to any route mask are ignored.
- R7: While the read lock is set, reads of any route mask return zero.
- R8: The pending status of port p is read at address 0x1000 + p*0x200 + 0x104. It returns one bit per existing pin in `reg_rdata[7:0]`, with bits above the pin count reading as zero.
- R9: Reads of any address that is not listed above return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 13 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, held between reads |
| pin_status | input | NUM_PORTS*8 | Pending bit per pin, port p at bits [8p+7:8p] |
| bank_irq | output | NUM_LINES | Registered bank interrupt lines |

## Verification
The merge is driven with several patterns:
- A single pending pin under the reset routing. This separates line 0 from the others.
- The same pin after it is copied into a second line. This shows that a pin can fan out to several lines.
- A pin on a port whose line 0 mask has been cleared. This shows that masks suppress a pin.
- Pending bits placed above a narrow port's pin count. These must raise nothing, which tells valid pins from invalid ones.

For the locks, mask writes are attempted after locking. The masks are then observed both through readback and through which lines a chosen pin raises. The pin is chosen so that a mask write that slipped through would change the line pattern.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int PIN_MAX   = 8;
  localparam int ADDR_W    = 13;
  localparam int DATA_W    = 32;
  localparam int WLOCK_BIT = 28;
  localparam int RLOCK_BIT = 27;

  localparam logic [ADDR_W-1:0] SEC_ADDR   = 13'h00C;
  localparam logic [ADDR_W-1:0] ROUTE_BASE = 13'h014;
  localparam logic [8:0]        STAT_OFS   = 9'h104;

  // Bit mask of the pins that exist on a port with n pins.
  function automatic logic [PIN_MAX-1:0] pin_valid(input logic [3:0] n);
    logic [PIN_MAX:0] t;
    t = (PIN_MAX+1)'(1) << n;
    return PIN_MAX'(t - (PIN_MAX+1)'(1));
  endfunction

  // Route mask decode: port in bits [7:5], line in [4:2] of (addr - base).
  function automatic logic route_sel(input logic [ADDR_W-1:0] a,
                                     input int nports, input int nlines,
                                     output logic [2:0] p, output logic [2:0] x);
    logic [ADDR_W-1:0] rel;
    rel = a - ROUTE_BASE;
    p   = rel[7:5];
    x   = rel[4:2];
    return (a >= ROUTE_BASE) && (rel[1:0] == 2'b00) && (rel[12:8] == 5'd0)
           && (int'(p) < nports) && (int'(x) < nlines);
  endfunction

  // Status decode: window bit 12, port in bits [11:9], offset in [8:0].
  function automatic logic status_sel(input logic [ADDR_W-1:0] a,
                                      input int nports, output logic [2:0] p);
    p = a[11:9];
    return a[12] && (a[8:0] == STAT_OFS) && (int'(p) < nports);
  endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int          NUM_PORTS = 8,
  parameter int          NUM_LINES = 8,
  parameter logic [31:0] PORT_PINS = 32'h5887_8348
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_en,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [DATA_W-1:0]                    wdata,
  output logic [NUM_PORTS*NUM_LINES*PIN_MAX-1:0] mask_flat,
  output logic                                 lock_w,
  output logic                                 lock_r
);

  logic       locked;
  logic       hit;
  logic [2:0] sel_p;
  logic [2:0] sel_x;

  assign locked = lock_w | lock_r;

  always_comb begin
    hit = route_sel(addr, NUM_PORTS, NUM_LINES, sel_p, sel_x);
  end

  // Sticky lock bits, cleared only by reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_w <= 1'b0;
      lock_r <= 1'b0;
    end else if (wr_en && addr == SEC_ADDR) begin
      lock_w <= lock_w | wdata[WLOCK_BIT];
      lock_r <= lock_r | wdata[RLOCK_BIT];
    end
  end

  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
    localparam logic [PIN_MAX-1:0] VALID = pin_valid(PORT_PINS[4*gp +: 4]);
    for (genvar gl = 0; gl < NUM_LINES; gl++) begin : g_line
      localparam logic [PIN_MAX-1:0] RST_VAL = (gl == 0) ? VALID : '0;
      logic [PIN_MAX-1:0] m_q;
      always_ff @(posedge clk) begin
        if (rst)
          m_q <= RST_VAL;
        else if (wr_en && hit && !locked && int'(sel_p) == gp && int'(sel_x) == gl)
          m_q <= wdata[PIN_MAX-1:0] & VALID;
      end
      assign mask_flat[(gp*NUM_LINES+gl)*PIN_MAX +: PIN_MAX] = m_q;
    end
  end

endmodule

// File: rtl/irq_route_merge.sv
module irq_route_merge
  import irq_route_pkg::*;
#(
  parameter int          NUM_PORTS = 8,
  parameter int          NUM_LINES = 8,
  parameter logic [31:0] PORT_PINS = 32'h5887_8348
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [NUM_PORTS*PIN_MAX-1:0]           pin_status,
  input  logic [NUM_PORTS*NUM_LINES*PIN_MAX-1:0] mask_flat,
  output logic [NUM_PORTS*PIN_MAX-1:0]           pend_flat,
  output logic [NUM_LINES-1:0]                   bank_irq
);

  logic [NUM_LINES-1:0] irq_d;

  // Pending inputs above a port's pin count are dropped here.
  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_pend
    localparam logic [PIN_MAX-1:0] VALID = pin_valid(PORT_PINS[4*gp +: 4]);
    assign pend_flat[gp*PIN_MAX +: PIN_MAX] = pin_status[gp*PIN_MAX +: PIN_MAX] & VALID;
  end

  always_comb begin
    for (int l = 0; l < NUM_LINES; l++) begin
      irq_d[l] = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        irq_d[l] = irq_d[l] |
          (|(pend_flat[p*PIN_MAX +: PIN_MAX] & mask_flat[(p*NUM_LINES+l)*PIN_MAX +: PIN_MAX]));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bank_irq <= '0;
    else     bank_irq <= irq_d;
  end

endmodule

// File: rtl/irq_route_rdmux.sv
module irq_route_rdmux
  import irq_route_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int NUM_LINES = 8
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   rd_en,
  input  logic [ADDR_W-1:0]                      addr,
  input  logic                                   lock_w,
  input  logic                                   lock_r,
  input  logic [NUM_PORTS*NUM_LINES*PIN_MAX-1:0] mask_flat,
  input  logic [NUM_PORTS*PIN_MAX-1:0]           pend_flat,
  output logic [DATA_W-1:0]                      rdata
);

  logic [DATA_W-1:0] rd_d;
  logic [2:0]        rp, rx, sp;
  logic              r_hit, s_hit;

  always_comb begin
    r_hit = route_sel(addr, NUM_PORTS, NUM_LINES, rp, rx);
    s_hit = status_sel(addr, NUM_PORTS, sp);
    rd_d  = '0;
    if (addr == SEC_ADDR) begin
      rd_d[WLOCK_BIT] = lock_w;
      rd_d[RLOCK_BIT] = lock_r;
    end else if (r_hit) begin
      if (!lock_r)
        rd_d[PIN_MAX-1:0] = mask_flat[(int'(rp)*NUM_LINES+int'(rx))*PIN_MAX +: PIN_MAX];
    end else if (s_hit) begin
      rd_d[PIN_MAX-1:0] = pend_flat[int'(sp)*PIN_MAX +: PIN_MAX];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_d;
  end

endmodule

// File: rtl/bank_irq_router.sv
module bank_irq_router
  import irq_route_pkg::*;
#(
  parameter int          NUM_PORTS = 8,
  parameter int          NUM_LINES = 8,
  parameter logic [31:0] PORT_PINS = 32'h5887_8348
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           reg_wr,
  input  logic                           reg_rd,
  input  logic [12:0]                    reg_addr,
  input  logic [31:0]                    reg_wdata,
  output logic [31:0]                    reg_rdata,
  input  logic [NUM_PORTS*8-1:0]         pin_status,
  output logic [NUM_LINES-1:0]           bank_irq
);

  localparam int MASK_BITS = NUM_PORTS * NUM_LINES * PIN_MAX;
  localparam int STAT_BITS = NUM_PORTS * PIN_MAX;

  logic [MASK_BITS-1:0] mask_flat;
  logic [STAT_BITS-1:0] pend_flat;
  logic                 lock_w;
  logic                 lock_r;

  irq_route_regs #(
    .NUM_PORTS(NUM_PORTS), .NUM_LINES(NUM_LINES), .PORT_PINS(PORT_PINS)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .mask_flat(mask_flat), .lock_w(lock_w), .lock_r(lock_r)
  );

  irq_route_merge #(
    .NUM_PORTS(NUM_PORTS), .NUM_LINES(NUM_LINES), .PORT_PINS(PORT_PINS)
  ) u_merge (
    .clk(clk), .rst(rst), .pin_status(pin_status), .mask_flat(mask_flat),
    .pend_flat(pend_flat), .bank_irq(bank_irq)
  );

  irq_route_rdmux #(
    .NUM_PORTS(NUM_PORTS), .NUM_LINES(NUM_LINES)
  ) u_rdmux (
    .clk(clk), .rst(rst), .rd_en(reg_rd), .addr(reg_addr),
    .lock_w(lock_w), .lock_r(lock_r), .mask_flat(mask_flat),
    .pend_flat(pend_flat), .rdata(reg_rdata)
  );

endmodule

// File: rtl/bank_irq_router_chk.sv
module bank_irq_router_chk #(
  parameter int NUM_PORTS = 8,
  parameter int NUM_LINES = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         reg_rd,
  input logic [12:0]                  reg_addr,
  input logic [31:0]                  reg_rdata,
  input logic [NUM_PORTS*8-1:0]       pin_status,
  input logic [NUM_LINES-1:0]         bank_irq,
  input logic                         lock_w,
  input logic                         lock_r,
  input logic [NUM_PORTS*NUM_LINES*8-1:0] mask_flat
);

  // R1: interrupt lines are quiet in the cycle after reset.
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (bank_irq == '0));

  // R3: no pending pin, no interrupt in the next cycle.
  a_r3_no_pend_no_irq: assert property (@(posedge clk) disable iff (rst)
    (pin_status == '0) |=> (bank_irq == '0));

  // R5: lock bits are sticky.
  a_r5_wlock_sticky: assert property (@(posedge clk) disable iff (rst)
    lock_w |=> lock_w);
  a_r5_rlock_sticky: assert property (@(posedge clk) disable iff (rst)
    lock_r |=> lock_r);

  // R6: masks frozen under either lock.
  a_r6_masks_frozen: assert property (@(posedge clk) disable iff (rst)
    (lock_w || lock_r) |=> $stable(mask_flat));

  // R9: address zero is unmapped and reads as zero.
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 13'h000) |=> (reg_rdata == '0));

endmodule

bind bank_irq_router bank_irq_router_chk #(
  .NUM_PORTS(NUM_PORTS), .NUM_LINES(NUM_LINES)
) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .pin_status(pin_status), .bank_irq(bank_irq),
  .lock_w(lock_w), .lock_r(lock_r), .mask_flat(mask_flat)
);

// File: tb/test_bank_irq_router.sv
`timescale 1ns/1ps
module test_bank_irq_router;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [12:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] pin_status = '0;
  logic [7:0]  bank_irq;

  int checks = 0;
  int errors = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  bank_irq_router i_bank_irq_router (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_status(pin_status), .bank_irq(bank_irq)
  );

  // Behavioural reference model
  int          pins [8] = '{8, 4, 3, 8, 7, 8, 8, 5};
  logic [7:0]  m_mask [8][8];
  bit          m_lw, m_lr;
  logic [7:0]  exp_irq;
  logic [31:0] exp_rdata;

  function automatic logic [7:0] vmask(int p);
    logic [7:0] v = '0;
    for (int b = 0; b < pins[p]; b++) v[b] = 1'b1;
    return v;
  endfunction

  always @(posedge clk) begin
    int a;
    logic [31:0] rd;
    started = 1;
    if (rst) begin
      for (int p = 0; p < 8; p++)
        for (int l = 0; l < 8; l++)
          m_mask[p][l] = (l == 0) ? vmask(p) : 8'h00;
      m_lw = 0; m_lr = 0; exp_irq = '0; exp_rdata = '0;
    end else begin
      for (int l = 0; l < 8; l++) begin
        exp_irq[l] = 1'b0;
        for (int p = 0; p < 8; p++)
          for (int b = 0; b < pins[p]; b++)
            if (pin_status[p*8+b] && m_mask[p][l][b]) exp_irq[l] = 1'b1;
      end
      a = int'(reg_addr);
      if (reg_rd) begin
        rd = '0;
        if (a == 12) begin
          rd[28] = m_lw; rd[27] = m_lr;
        end else if (a >= 20 && a < 20 + 8*32 && (a % 4) == 0) begin
          if (!m_lr) rd[7:0] = m_mask[(a-20)/32][((a-20)%32)/4];
        end else if (a >= 4096 && ((a-4096) % 512) == 260 && (a-4096)/512 < 8) begin
          rd[7:0] = pin_status[((a-4096)/512)*8 +: 8] & vmask((a-4096)/512);
        end
        exp_rdata = rd;
      end
      if (reg_wr) begin
        if (a == 12) begin
          m_lw = m_lw | reg_wdata[28];
          m_lr = m_lr | reg_wdata[27];
        end else if (a >= 20 && a < 20 + 8*32 && (a % 4) == 0 && !(m_lw || m_lr)) begin
          m_mask[(a-20)/32][((a-20)%32)/4] = reg_wdata[7:0] & vmask((a-20)/32);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R2, R3)
  always @(negedge clk) begin
    if (started && !rst) begin
      check("R3 model irq", {24'h0, bank_irq}, {24'h0, exp_irq});
      check("R2 model rdata", reg_rdata, exp_rdata);
    end
  end

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_chk(input logic [12:0] a, input string tag, input logic [31:0] exp);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    check(tag, reg_rdata, exp);
  endtask

  task automatic irq_chk(input logic [63:0] st, input string tag, input logic [7:0] exp);
    @(negedge clk);
    pin_status = st;
    @(negedge clk);
    @(negedge clk);
    check(tag, {24'h0, bank_irq}, {24'h0, exp});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 irq after reset", {24'h0, bank_irq}, 32'h0);
    rd_chk(13'h00C, "R1 R5 locks clear", 32'h0);
    rd_chk(13'h034, "R1 port1 line0 default", 32'h0000_000F);
    rd_chk(13'h020, "R1 port0 line3 zero", 32'h0);

    irq_chk(64'h1 << 17, "R3 single pin line0", 8'h01);
    wr(13'h068, 32'hFF);
    rd_chk(13'h068, "R4 narrow port mask readback", 32'h0000_0007);
    irq_chk(64'h1 << 17, "R3 fanout to line5", 8'h21);

    irq_chk(64'h1 << 14, "R4 pin above count ignored", 8'h00);
    rd_chk(13'h1304, "R4 R8 status of narrow port", 32'h0);
    irq_chk((64'h1 << 60) | 64'h1, "R3 two ports", 8'h01);
    rd_chk(13'h1F04, "R8 status port7", 32'h0000_0010);

    wr(13'h014, 32'h0);
    wr(13'h110, 32'h10);
    irq_chk(64'h1, "R3 cleared mask suppresses", 8'h00);
    irq_chk(64'h1 << 60, "R3 port7 line7 and line0", 8'h81);

    rd_chk(13'h000, "R9 unmapped 0x000", 32'h0);
    rd_chk(13'h010, "R9 unmapped 0x010", 32'h0);

    wr(13'h00C, 32'h1000_0000);
    rd_chk(13'h00C, "R5 write lock set", 32'h1000_0000);
    wr(13'h078, 32'hAA);
    rd_chk(13'h078, "R6 write ignored under wlock", 32'h0);
    wr(13'h00C, 32'h0);
    rd_chk(13'h00C, "R5 lock sticky", 32'h1000_0000);

    do_reset();
    rd_chk(13'h00C, "R1 locks cleared by reset", 32'h0);
    wr(13'h09C, 32'h55);
    rd_chk(13'h09C, "R2 port4 line2 readback", 32'h0000_0055);
    wr(13'h00C, 32'h0800_0000);
    rd_chk(13'h00C, "R5 read lock set", 32'h0800_0000);
    rd_chk(13'h09C, "R7 mask hidden under rlock", 32'h0);
    wr(13'h09C, 32'h01);
    irq_chk(64'h1 << 34, "R6 mask unchanged under rlock", 8'h05);
    rd_chk(13'h1904, "R8 status readable under rlock", 32'h0000_0004);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule